// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Controller

This block sits between a 6502-family CPU bus and the storage of a console cartridge. It sees a 13-bit address whose top bit selects the cartridge, plus read and write strobes and write data. Within the cartridge it maps a 2 KB window that can show one of seven 2 KB ROM banks or a 1 KB RAM block. Beside the window sit a 512-byte region that exposes one 256-byte page of a second 1 KB RAM, and a fixed 1.5 KB area that always shows the top of the 16 KB ROM.

Mapping changes are made by touching trigger addresses near the top of the fixed area. A read or a write to a trigger address changes the mapping. Both RAM regions have a separate write port and read port at different addresses. A read issued to a write port stores 0xFF into the addressed byte and returns 0xFF. Each access occupies one clock with a strobe high. The read data is registered and appears, flagged valid, in the following cycle. ROM and RAM storage sit inside the block. The ROM content is computed from the address, so that it can be checked.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After synchronous reset the window shows ROM bank 0, the window RAM is unmapped, RAM page 0 is selected, and `cpu_rvalid` is 0 with `cpu_rdata` 0x00.
- R2: With the window RAM unmapped, a read at cartridge offset o < 0x800 returns ROM byte bank*0x800 + o. The ROM byte at address a (14 bits) is a[7:0] XOR {00,a[13:8]} XOR 0xA5.
- R3: A read at cartridge offset o in 0xA00..0xFFF returns ROM byte 0x3000 + o, which is the last 1.5 KB of ROM.
- R4: A read or write at offset 0xFE0+n (n = 0..6) selects ROM bank n and unmaps the window RAM. A read of a trigger address still returns its fixed-ROM byte.
- R5: A read or write at offset 0xFE7 maps the first RAM into the window. Offsets 0x000..0x3FF are then its write port and 0x400..0x7FF its read port, both at RAM index o & 0x3FF. The RAM contents survive unmapping.
- R6: A read or write at offset 0xFE8+p (p = 0..3) selects RAM page p. Offsets 0x800..0x8FF write, and 0x900..0x9FF read, second-RAM index p*0x100 + (o & 0xFF).
- R7: A read at either RAM write port writes 0xFF to the addressed byte and returns 0xFF.
- R8: Writes to a RAM read port or to ROM change no stored byte.
- R9: Accesses with address bit 12 low change no mapping and no RAM byte, and produce `cpu_rvalid` = 0 with `cpu_rdata` = 0x00.
- R10: Read data and `cpu_rvalid` appear in the cycle after the read. A mapping change made by an access applies from the next access on, including one in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 13 | CPU address; bit 12 is cartridge select |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one cycle after the read |
| cpu_rvalid | output | 1 | High when cpu_rdata carries cartridge read data |

## Verification
A single read of a trigger address does two things in the same cycle. It fetches a fixed-ROM byte, and it rewrites the bank, RAM-enable or page register that steers the next fetch. The bench reads trigger addresses and checks that the returned byte is the fixed-ROM value. It then reads the window or the paged region and checks that the data follows the new mapping. A back-to-back case places a write to a bank trigger directly before a window read, with no idle cycle between them. Reads of write ports are judged on two things: the 0xFF they return at once, and the 0xFF found afterwards through the matching read port.

// File: rtl/cart_pkg.sv
package cart_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_ROM,
    SRC_RAM_LO,
    SRC_RAM_PG,
    SRC_FILL
  } rsrc_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // ROM contents are a pure function of the byte address
  function automatic logic [7:0] rom_pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

endpackage

// File: rtl/cart_rom.sv
module cart_rom #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  always_ff @(posedge clk) begin
    if (en) q <= cart_pkg::rom_pattern(16'(addr));
  end
endmodule

// File: rtl/cart_sram.sv
module cart_sram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wd,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    q <= mem[addr];
  end
endmodule

// File: rtl/cart_map_regs.sv
module cart_map_regs #(
  parameter int BANK_W = 3,
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_bank,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              set_ram,
  input  logic              set_page,
  input  logic [PAGE_W-1:0] page_in,
  output logic [BANK_W-1:0] bank_q,
  output logic              ram_en_q,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q   <= '0;
      ram_en_q <= 1'b0;
      page_q   <= '0;
    end else begin
      if (set_bank) begin
        bank_q   <= bank_in;
        ram_en_q <= 1'b0;
      end
      if (set_ram)  ram_en_q <= 1'b1;
      if (set_page) page_q   <= page_in;
    end
  end
endmodule

// File: rtl/cart_decode.sv
module cart_decode
  import cart_pkg::*;
#(
  parameter int          ROM_AW      = 14,
  parameter int          WIN_AW      = 11,
  parameter int          RAM_AW      = 10,
  parameter int          PAGE_AW     = 8,
  parameter int          FIXED_BYTES = 1536,
  parameter logic [11:0] HOT_BASE    = 12'hFE0
) (
  input  logic [12:0]              addr,
  input  logic                     rd,
  input  logic                     wr,
  input  logic [7:0]               wdata,
  input  logic [ROM_AW-WIN_AW-1:0] bank,
  input  logic                     ram_en,
  input  logic [RAM_AW-PAGE_AW-1:0] page,
  output logic                     set_bank,
  output logic [ROM_AW-WIN_AW-1:0] bank_in,
  output logic                     set_ram,
  output logic                     set_page,
  output logic [RAM_AW-PAGE_AW-1:0] page_in,
  output logic                     rom_en,
  output logic [ROM_AW-1:0]        rom_addr,
  output logic                     lo_we,
  output logic [RAM_AW-1:0]        lo_addr,
  output logic                     pg_we,
  output logic [RAM_AW-1:0]        pg_addr,
  output logic [7:0]               ram_wd,
  output rsrc_e                    src
);
  localparam int BANK_W = ROM_AW - WIN_AW;
  localparam int PAGE_W = RAM_AW - PAGE_AW;
  localparam int NBANK  = (1 << BANK_W) - 1;
  localparam int NPAGE  = 1 << PAGE_W;

  localparam logic [11:0] WIN_END  = 12'(1 << WIN_AW);
  localparam logic [11:0] LO_WEND  = 12'(1 << RAM_AW);
  localparam logic [11:0] PG_WEND  = 12'((1 << WIN_AW) + (1 << PAGE_AW));
  localparam logic [11:0] PG_END   = 12'((1 << WIN_AW) + 2 * (1 << PAGE_AW));
  localparam logic [11:0] FIX_BASE = 12'(4096 - FIXED_BYTES);
  localparam logic [11:0] HOT_N    = 12'(NBANK + 1 + NPAGE);
  localparam logic [11:0] HOT_RAM  = 12'(NBANK);
  localparam logic [11:0] HOT_PG0  = 12'(NBANK + 1);
  localparam logic [ROM_AW-1:0] ROM_FIX = ROM_AW'((1 << ROM_AW) - FIXED_BYTES);

  logic [11:0] off, hd, hp;
  logic        sel, acc, rd_a, in_win, in_pg, lo_wport, pg_wport, hot;

  always_comb begin
    off      = addr[11:0];
    sel      = addr[12];
    acc      = sel & (rd | wr);
    rd_a     = sel & rd;
    in_win   = off < WIN_END;
    in_pg    = (off >= WIN_END) && (off < PG_END);
    lo_wport = off < LO_WEND;
    pg_wport = off < PG_WEND;

    hd       = off - HOT_BASE;
    hp       = hd - HOT_PG0;
    hot      = acc && (off >= HOT_BASE) && (hd < HOT_N);
    set_bank = hot && (hd < HOT_RAM);
    set_ram  = hot && (hd == HOT_RAM);
    set_page = hot && (hd > HOT_RAM);
    bank_in  = hd[BANK_W-1:0];
    page_in  = hp[PAGE_W-1:0];

    rom_addr = in_win ? {bank, off[WIN_AW-1:0]}
                      : ROM_FIX + ROM_AW'(off - FIX_BASE);
    rom_en   = rd_a & ((in_win & ~ram_en) | (~in_win & ~in_pg));

    ram_wd   = rd ? FILL_BYTE : wdata;
    lo_addr  = off[RAM_AW-1:0];
    lo_we    = acc & in_win & ram_en & lo_wport;
    pg_addr  = {page, off[PAGE_AW-1:0]};
    pg_we    = acc & in_pg & pg_wport;

    src = SRC_NONE;
    if (rd_a) begin
      if (in_win)     src = ram_en ? (lo_wport ? SRC_FILL : SRC_RAM_LO) : SRC_ROM;
      else if (in_pg) src = pg_wport ? SRC_FILL : SRC_RAM_PG;
      else            src = SRC_ROM;
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_pkg::*;
#(
  parameter int          ROM_AW      = 14,
  parameter int          WIN_AW      = 11,
  parameter int          RAM_AW      = 10,
  parameter int          PAGE_AW     = 8,
  parameter int          FIXED_BYTES = 1536,
  parameter logic [11:0] HOT_BASE    = 12'hFE0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [12:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_rvalid
);
  localparam int BANK_W = ROM_AW - WIN_AW;
  localparam int PAGE_W = RAM_AW - PAGE_AW;

  logic [BANK_W-1:0] bank_q, bank_in;
  logic [PAGE_W-1:0] page_q, page_in;
  logic              ram_en_q, set_bank, set_ram, set_page;
  logic              rom_en, ram_lo_we, ram_pg_we;
  logic [ROM_AW-1:0] rom_addr;
  logic [RAM_AW-1:0] lo_addr, pg_addr;
  logic [7:0]        ram_wd, rom_q, lo_q, pg_q;
  rsrc_e             src, src_q;

  cart_decode #(
    .ROM_AW(ROM_AW), .WIN_AW(WIN_AW), .RAM_AW(RAM_AW), .PAGE_AW(PAGE_AW),
    .FIXED_BYTES(FIXED_BYTES), .HOT_BASE(HOT_BASE)
  ) u_dec (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .wdata(cpu_wdata),
    .bank(bank_q), .ram_en(ram_en_q), .page(page_q),
    .set_bank(set_bank), .bank_in(bank_in), .set_ram(set_ram),
    .set_page(set_page), .page_in(page_in),
    .rom_en(rom_en), .rom_addr(rom_addr),
    .lo_we(ram_lo_we), .lo_addr(lo_addr),
    .pg_we(ram_pg_we), .pg_addr(pg_addr),
    .ram_wd(ram_wd), .src(src)
  );

  cart_map_regs #(.BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst(rst),
    .set_bank(set_bank), .bank_in(bank_in), .set_ram(set_ram),
    .set_page(set_page), .page_in(page_in),
    .bank_q(bank_q), .ram_en_q(ram_en_q), .page_q(page_q)
  );

  cart_rom #(.AW(ROM_AW)) u_rom (
    .clk(clk), .en(rom_en), .addr(rom_addr), .q(rom_q)
  );

  cart_sram #(.AW(RAM_AW)) u_ram_lo (
    .clk(clk), .we(ram_lo_we), .addr(lo_addr), .wd(ram_wd), .q(lo_q)
  );

  cart_sram #(.AW(RAM_AW)) u_ram_pg (
    .clk(clk), .we(ram_pg_we), .addr(pg_addr), .wd(ram_wd), .q(pg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_NONE;
    else     src_q <= src;
  end

  always_comb begin
    unique case (src_q)
      SRC_ROM:    cpu_rdata = rom_q;
      SRC_RAM_LO: cpu_rdata = lo_q;
      SRC_RAM_PG: cpu_rdata = pg_q;
      SRC_FILL:   cpu_rdata = FILL_BYTE;
      default:    cpu_rdata = 8'h00;
    endcase
  end

  assign cpu_rvalid = (src_q != SRC_NONE);
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [12:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic        cpu_rvalid,
  input logic [2:0]  bank_q,
  input logic        ram_en_q,
  input logic [1:0]  page_q,
  input logic        ram_lo_we,
  input logic        ram_pg_we
);
  logic acc;
  assign acc = cpu_addr[12] & (cpu_rd | cpu_wr);

  a_r4_bank_hot: assert property (@(posedge clk) disable iff (rst)
    (acc && cpu_addr[11:3] == 9'h1FC && cpu_addr[2:0] != 3'd7)
      |=> (bank_q == $past(cpu_addr[2:0])) && !ram_en_q);

  a_r5_ram_hot: assert property (@(posedge clk) disable iff (rst)
    (acc && cpu_addr[11:0] == 12'hFE7) |=> ram_en_q);

  a_r6_page_hot: assert property (@(posedge clk) disable iff (rst)
    (acc && cpu_addr[11:2] == 10'h3FA) |=> (page_q == $past(cpu_addr[1:0])));

  a_r7_fill_read: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[12:8] == 5'h18) |=> (cpu_rvalid && cpu_rdata == 8'hFF));

  a_r9_no_store: assert property (@(posedge clk) disable iff (rst)
    !cpu_addr[12] |-> (!ram_lo_we && !ram_pg_we));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[12]) |=> cpu_rvalid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd && cpu_addr[12]) |=> !cpu_rvalid);
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
  .bank_q(bank_q), .ram_en_q(ram_en_q), .page_q(page_q),
  .ram_lo_we(ram_lo_we), .ram_pg_we(ram_pg_we)
);

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cart_bank_ctrl dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  // op: 0 idle, 1 read, 2 write; kind: 0 none, 1 data, 2 rom byte at val, 3 invalid
  typedef struct packed {
    logic [1:0]  op;
    logic [12:0] a;
    logic [7:0]  d;
    logic [1:0]  kind;
    logic [13:0] val;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 13'h1000, 8'h00, 2'd2, 14'h0000, 4'd2},   // R2 bank 0 after reset
    '{2'd1, 13'h1FE3, 8'h00, 2'd2, 14'h3FE3, 4'd4},   // R4 trigger read gives fixed ROM
    '{2'd1, 13'h1123, 8'h00, 2'd2, 14'h1923, 4'd2},   // R2 bank 3
    '{2'd1, 13'h17FF, 8'h00, 2'd2, 14'h1FFF, 4'd2},
    '{2'd2, 13'h1FE6, 8'h00, 2'd0, 14'h0000, 4'd4},   // R4 write trigger
    '{2'd1, 13'h1005, 8'h00, 2'd2, 14'h3005, 4'd4},
    '{2'd1, 13'h1A00, 8'h00, 2'd2, 14'h3A00, 4'd3},   // R3
    '{2'd1, 13'h1FFF, 8'h00, 2'd2, 14'h3FFF, 4'd3},
    '{2'd2, 13'h1FE7, 8'h00, 2'd0, 14'h0000, 4'd5},   // R5 map RAM
    '{2'd2, 13'h1010, 8'h3C, 2'd0, 14'h0000, 4'd5},
    '{2'd1, 13'h1410, 8'h00, 2'd1, 14'h003C, 4'd5},
    '{2'd2, 13'h13FF, 8'h77, 2'd0, 14'h0000, 4'd5},
    '{2'd1, 13'h17FF, 8'h00, 2'd1, 14'h0077, 4'd5},
    '{2'd2, 13'h1410, 8'h99, 2'd0, 14'h0000, 4'd8},   // R8 write to read port
    '{2'd1, 13'h1410, 8'h00, 2'd1, 14'h003C, 4'd8},
    '{2'd1, 13'h1020, 8'h00, 2'd1, 14'h00FF, 4'd7},   // R7 read of write port
    '{2'd1, 13'h1420, 8'h00, 2'd1, 14'h00FF, 4'd7},
    '{2'd1, 13'h1FE2, 8'h00, 2'd2, 14'h3FE2, 4'd4},   // R4 unmaps RAM
    '{2'd1, 13'h1410, 8'h00, 2'd2, 14'h1410, 4'd4},
    '{2'd1, 13'h1FE7, 8'h00, 2'd2, 14'h3FE7, 4'd5},   // R5 read trigger remaps
    '{2'd1, 13'h1410, 8'h00, 2'd1, 14'h003C, 4'd5},
    '{2'd2, 13'h1842, 8'h11, 2'd0, 14'h0000, 4'd6},   // R6 page 0
    '{2'd1, 13'h1942, 8'h00, 2'd1, 14'h0011, 4'd6},
    '{2'd1, 13'h1FE9, 8'h00, 2'd2, 14'h3FE9, 4'd6},
    '{2'd2, 13'h1842, 8'h22, 2'd0, 14'h0000, 4'd6},
    '{2'd1, 13'h1942, 8'h00, 2'd1, 14'h0022, 4'd6},
    '{2'd1, 13'h1FE8, 8'h00, 2'd2, 14'h3FE8, 4'd6},
    '{2'd1, 13'h1942, 8'h00, 2'd1, 14'h0011, 4'd6},
    '{2'd2, 13'h1FEB, 8'h00, 2'd0, 14'h0000, 4'd6},
    '{2'd1, 13'h1842, 8'h00, 2'd1, 14'h00FF, 4'd7},   // R7 paged write port
    '{2'd1, 13'h1942, 8'h00, 2'd1, 14'h00FF, 4'd7},
    '{2'd2, 13'h1FE8, 8'h00, 2'd0, 14'h0000, 4'd6},
    '{2'd1, 13'h1942, 8'h00, 2'd1, 14'h0011, 4'd6},
    '{2'd2, 13'h1A10, 8'h00, 2'd0, 14'h0000, 4'd8},   // R8 write to ROM
    '{2'd1, 13'h1A10, 8'h00, 2'd2, 14'h3A10, 4'd8},
    '{2'd1, 13'h0942, 8'h00, 2'd3, 14'h0000, 4'd9},   // R9 deselected
    '{2'd2, 13'h0842, 8'hEE, 2'd0, 14'h0000, 4'd9},
    '{2'd1, 13'h0FE9, 8'h00, 2'd3, 14'h0000, 4'd9},
    '{2'd1, 13'h1942, 8'h00, 2'd1, 14'h0011, 4'd9},
    '{2'd2, 13'h1942, 8'h55, 2'd0, 14'h0000, 4'd8},   // R8 write to paged read port
    '{2'd1, 13'h1942, 8'h00, 2'd1, 14'h0011, 4'd8},
    '{2'd0, 13'h1000, 8'h00, 2'd3, 14'h0000, 4'd10}   // R10 no read, no valid
  };

  function automatic logic [7:0] romv(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
  endfunction

  task automatic check(input int rq, input logic ev, input logic [7:0] ed);
    total++;
    if (cpu_rvalid !== ev || cpu_rdata !== ed) begin
      bad++;
      $display("FAIL R%0d: rvalid=%0b rdata=%02h expected rvalid=%0b rdata=%02h",
               rq, cpu_rvalid, cpu_rdata, ev, ed);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [12:0] a, input logic [7:0] d);
    cpu_rd    = (op == 2'd1);
    cpu_wr    = (op == 2'd2);
    cpu_addr  = a;
    cpu_wdata = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(2'd0, 13'h0000, 8'h00);
    repeat (3) @(negedge clk);
    check(1, 1'b0, 8'h00);                           // R1 reset outputs
    rst = 1'b0;

    foreach (VEC[i]) begin
      @(negedge clk);
      drive(VEC[i].op, VEC[i].a, VEC[i].d);
      @(negedge clk);
      drive(2'd0, 13'h0000, 8'h00);
      case (VEC[i].kind)
        2'd1: check(int'(VEC[i].rq), 1'b1, VEC[i].val[7:0]);
        2'd2: check(int'(VEC[i].rq), 1'b1, romv(VEC[i].val));
        2'd3: check(int'(VEC[i].rq), 1'b0, 8'h00);
        default: ;
      endcase
    end

    // R10 back-to-back: trigger write, then window read in the next cycle
    @(negedge clk);
    drive(2'd2, 13'h1FE1, 8'h00);
    @(negedge clk);
    drive(2'd1, 13'h1000, 8'h00);
    check(10, 1'b0, 8'h00);
    @(negedge clk);
    drive(2'd0, 13'h0000, 8'h00);
    check(10, 1'b1, romv(14'h0800));
    // R10 data stays only one cycle flagged
    @(negedge clk);
    check(10, 1'b0, 8'h00);

    // R1 reset restores mapping, RAM keeps contents
    @(negedge clk);
    drive(2'd2, 13'h1FE7, 8'h00);
    @(negedge clk);
    drive(2'd2, 13'h1FEA, 8'h00);
    @(negedge clk);
    drive(2'd0, 13'h0000, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1, 1'b0, 8'h00);
    drive(2'd1, 13'h1410, 8'h00);
    @(negedge clk);
    drive(2'd0, 13'h0000, 8'h00);
    check(1, 1'b1, romv(14'h0410));                  // R1 bank 0, RAM unmapped
    drive(2'd1, 13'h1942, 8'h00);
    @(negedge clk);
    drive(2'd0, 13'h0000, 8'h00);
    check(1, 1'b1, 8'h11);                           // R1 page 0

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule